// File: doc/BRIEF.md
# Paged Nonvolatile Memory Write Controller

This block is the device-side control logic of a byte-wide paged nonvolatile memory, with a register array standing in for the storage cells. A host sees a static-RAM style bus: an address, a bidirectional byte-wide data bus, and active-low chip enable, output enable and write enable. All control pins, the address and the data bus pass through a synchroniser of equal depth. Edges are then found on the synchronised samples.

Writes are always guarded. Every data write must come straight after a three-write unlock command. The first data write after the unlock fixes the target page. Further bytes for that page are gathered in a page buffer. Each accepted byte restarts a byte-load window, and when that window expires the block enters a programming period of fixed length. At the end of that period only the loaded bytes are copied into the array. A write that is not unlocked runs the same timers but stores nothing. From the first loaded byte until programming ends, reads return a status byte in place of array data.

The full-size array has 131072 bytes (`ADDR_W` = 17). The default `ADDR_W` is 11 so that the register array stays small at elaboration. The programming and load-window lengths are parameters counted in clock cycles.

Top module: `eeprom_page_ctrl`

## Requirements
- R1: After reset every array byte reads 0xFF and the block is idle, so reads return array data.
- R2: The block drives the data bus only while chip enable and output enable are low and write enable is high. When idle, the byte driven is the array byte at the address.
- R3: A write is recognised only while chip enable and write enable are low and output enable is high. The address is taken when the later of the two enables falls. The data is taken from the last sample before the first of the two enables rises.
- R4: The unlock command is three writes in order: address 0x5555 with data 0xAA, then 0x2AAA with 0x55, then 0x5555 with 0xA0. Addresses are compared on the low `ADDR_W` bits. Command writes are not stored in the array.
- R5: The write that follows an unlock fixes the page as address bits `ADDR_W-1`..7. Later writes to another page while loading are dropped and do not restart the load window.
- R6: Each accepted byte restarts a window of `LOAD_WIN` cycles. When the window expires, programming runs for `PROG_CYC` cycles, and then the block is idle again.
- R7: Bytes of the page may be loaded in any order, and when a byte is rewritten the last value wins. After programming only the loaded bytes hold new data, and every other array byte is unchanged.
- R8: A write in idle that does not unlock, or that breaks the unlock sequence, returns the unlock detector to its start. That write runs the load and programming timers but nothing is stored.
- R9: While busy (loading or programming), a read at any address returns a status byte built from the last accepted write data d: bit 7 = ~d[7], bit 6 = toggle flag, bits 5..0 = d[5:0]. The toggle flag is cleared when the busy period starts and inverts at the start of each read while busy, so the first read in a busy period shows bit 6 = 1.
- R10: Writes made during programming are ignored. They change neither the array nor the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | ADDR_W | Byte address |
| data_io | inout | 8 | Bidirectional data bus |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |

## Verification
The bench sweeps the whole default array before and after a series of page operations and compares every byte with a model kept in the bench. This catches a controller that programs unloaded bytes, writes the command bytes or stores a byte into the wrong page. It drives out-of-order loads, rewrites of a byte and a stray write to another page, so a design that keeps the first value of a byte or follows the stray write shows up. Broken unlock sequences, writes with no unlock, and writes masked by output enable or chip enable must leave the array unchanged. The status byte is checked in both toggle phases, before and after the programming deadline, and for a write made during programming, which exposes wrong busy timing or a status byte that follows ignored writes.

// File: rtl/epc_pkg.sv
package epc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } epc_state_e;

  localparam logic [15:0] CMD_ADDR_A = 16'h5555;
  localparam logic [15:0] CMD_ADDR_B = 16'h2AAA;
  localparam logic [7:0]  CMD_DAT_1  = 8'hAA;
  localparam logic [7:0]  CMD_DAT_2  = 8'h55;
  localparam logic [7:0]  CMD_DAT_3  = 8'hA0;
endpackage

// File: rtl/epc_pin_sync.sv
module epc_pin_sync #(
  parameter int unsigned   W      = 1,
  parameter int unsigned   STAGES = 2,
  parameter logic [W-1:0]  RST    = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[0] <= RST;
        else         stg_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= RST;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/epc_bus_decode.sv
module epc_bus_decode #(
  parameter int unsigned ADDR_W = 11,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_n_i,
  input  logic              oe_n_i,
  input  logic              we_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              wr_commit_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              rd_act_o,
  output logic              rd_start_o
);
  logic wr_act, wr_act_q, rd_act_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  assign wr_act   = ~ce_n_i & ~we_n_i & oe_n_i;
  assign rd_act_o = ~ce_n_i & ~oe_n_i & we_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_act_q <= 1'b0;
      rd_act_q <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
    end else begin
      wr_act_q <= wr_act;
      rd_act_q <= rd_act_o;
      if (wr_act && !wr_act_q) addr_q <= addr_i;
      // keep the last sample seen while the write is open
      if (wr_act) data_q <= data_i;
    end
  end

  assign wr_commit_o = wr_act_q & ~wr_act;
  assign wr_addr_o   = addr_q;
  assign wr_data_o   = data_q;
  assign rd_start_o  = rd_act_o & ~rd_act_q;
endmodule

// File: rtl/epc_unlock.sv
module epc_unlock
  import epc_pkg::*;
#(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              wr_i,
  input  logic              clr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic              hit_o,
  output logic              armed_o
);
  localparam logic [ADDR_W-1:0] ADR_A = ADDR_W'(CMD_ADDR_A);
  localparam logic [ADDR_W-1:0] ADR_B = ADDR_W'(CMD_ADDR_B);

  logic [1:0] step_q;
  logic       match;

  always_comb begin
    unique case (step_q)
      2'd0:    match = (addr_i == ADR_A) && (data_i == CMD_DAT_1);
      2'd1:    match = (addr_i == ADR_B) && (data_i == CMD_DAT_2);
      2'd2:    match = (addr_i == ADR_A) && (data_i == CMD_DAT_3);
      default: match = 1'b0;
    endcase
  end

  assign hit_o   = en_i & wr_i & match;
  assign armed_o = (step_q == 2'd3);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 step_q <= 2'd0;
    else if (clr_i || !en_i)     step_q <= 2'd0;
    else if (wr_i && !armed_o)   step_q <= match ? step_q + 2'd1 : 2'd0;
  end
endmodule

// File: rtl/epc_page_buf.sv
module epc_page_buf #(
  parameter int unsigned BYTE_W = 7,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PAGE_BYTES = 2 ** BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [BYTE_W-1:0] idx_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] page_data_o [PAGE_BYTES],
  output logic [PAGE_BYTES-1:0] vld_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= '0;
      for (int b = 0; b < PAGE_BYTES; b++) page_data_o[b] <= '0;
    end else if (clr_i) begin
      vld_o <= '0;
    end else if (wr_i) begin
      vld_o[idx_i]       <= 1'b1;
      page_data_o[idx_i] <= data_i;
    end
  end
endmodule

// File: rtl/eeprom_page_ctrl.sv
module eeprom_page_ctrl
  import epc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 11,
  parameter int unsigned BYTE_W      = 7,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned LOAD_WIN    = 18750,
  parameter int unsigned PROG_CYC    = 1250000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  inout  wire  [7:0]        data_io,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni
);
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned DEPTH      = 2 ** ADDR_W;
  localparam int unsigned PAGE_BYTES = 2 ** BYTE_W;
  localparam int unsigned PAGE_W     = ADDR_W - BYTE_W;
  localparam int unsigned LW_W       = $clog2(LOAD_WIN + 1);
  localparam int unsigned PC_W       = $clog2(PROG_CYC + 1);

  logic [2:0]              ctrl_s;
  logic [ADDR_W-1:0]       addr_s;
  logic [DATA_W-1:0]       din_s;
  logic                    wr_commit, rd_act, rd_start;
  logic [ADDR_W-1:0]       wr_addr;
  logic [DATA_W-1:0]       wr_data;
  logic [PAGE_W-1:0]       wr_page;
  logic                    cmd_hit, armed, unlock_clr;

  epc_state_e              state_q;
  logic [PAGE_W-1:0]       page_q;
  logic                    ok_q, toggle_q, busy;
  logic [DATA_W-1:0]       last_d_q;
  logic [LW_W-1:0]         lcnt_q;
  logic [PC_W-1:0]         pcnt_q;
  logic                    buf_wr, prog_end;
  logic [DATA_W-1:0]       page_data [PAGE_BYTES];
  logic [PAGE_BYTES-1:0]   page_vld;
  logic [DATA_W-1:0]       mem_q [DEPTH];
  logic [DATA_W-1:0]       dout_q;
  logic                    drv_q;

  epc_pin_sync #(.W(3), .STAGES(SYNC_STAGES), .RST(3'b111)) i_ctrl_sync (
    .clk_i, .rst_ni, .d_i({ce_ni, oe_ni, we_ni}), .q_o(ctrl_s)
  );

  epc_pin_sync #(.W(ADDR_W + DATA_W), .STAGES(SYNC_STAGES), .RST('0)) i_bus_sync (
    .clk_i, .rst_ni, .d_i({addr_i, data_io}), .q_o({addr_s, din_s})
  );

  epc_bus_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_decode (
    .clk_i, .rst_ni,
    .ce_n_i(ctrl_s[2]), .oe_n_i(ctrl_s[1]), .we_n_i(ctrl_s[0]),
    .addr_i(addr_s), .data_i(din_s),
    .wr_commit_o(wr_commit), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .rd_act_o(rd_act), .rd_start_o(rd_start)
  );

  assign wr_page    = wr_addr[ADDR_W-1:BYTE_W];
  assign busy       = (state_q != ST_IDLE);
  assign unlock_clr = (state_q == ST_IDLE) && wr_commit && armed;

  epc_unlock #(.ADDR_W(ADDR_W)) i_unlock (
    .clk_i, .rst_ni,
    .en_i(state_q == ST_IDLE), .wr_i(wr_commit), .clr_i(unlock_clr),
    .addr_i(wr_addr), .data_i(wr_data),
    .hit_o(cmd_hit), .armed_o(armed)
  );

  assign buf_wr = wr_commit &&
                  (((state_q == ST_IDLE) && armed) ||
                   ((state_q == ST_LOAD) && ok_q && (wr_page == page_q)));
  assign prog_end = (state_q == ST_PROG) && (pcnt_q == PC_W'(PROG_CYC - 1));

  epc_page_buf #(.BYTE_W(BYTE_W), .DATA_W(DATA_W)) i_page_buf (
    .clk_i, .rst_ni,
    .clr_i(prog_end), .wr_i(buf_wr),
    .idx_i(wr_addr[BYTE_W-1:0]), .data_i(wr_data),
    .page_data_o(page_data), .vld_o(page_vld)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      page_q   <= '0;
      ok_q     <= 1'b0;
      last_d_q <= '0;
      toggle_q <= 1'b0;
      lcnt_q   <= '0;
      pcnt_q   <= '0;
    end else begin
      if (rd_start && busy) toggle_q <= ~toggle_q;
      unique case (state_q)
        ST_IDLE: begin
          if (wr_commit && !cmd_hit) begin
            state_q  <= ST_LOAD;
            page_q   <= wr_page;
            ok_q     <= armed;
            last_d_q <= wr_data;
            lcnt_q   <= '0;
            toggle_q <= 1'b0;
          end
        end
        ST_LOAD: begin
          if (wr_commit && (wr_page == page_q)) begin
            lcnt_q   <= '0;
            last_d_q <= wr_data;
          end else if (lcnt_q == LW_W'(LOAD_WIN - 1)) begin
            state_q <= ST_PROG;
            pcnt_q  <= '0;
          end else begin
            lcnt_q <= lcnt_q + LW_W'(1);
          end
        end
        ST_PROG: begin
          if (prog_end) state_q <= ST_IDLE;
          else          pcnt_q  <= pcnt_q + PC_W'(1);
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // array: erased state is all ones; only flagged bytes are programmed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else if (prog_end && ok_q) begin
      for (int b = 0; b < PAGE_BYTES; b++)
        if (page_vld[b]) mem_q[{page_q, BYTE_W'(b)}] <= page_data[b];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= '0;
      drv_q  <= 1'b0;
    end else begin
      drv_q  <= rd_act;
      dout_q <= busy ? {~last_d_q[7], toggle_q, last_d_q[5:0]} : mem_q[addr_s];
    end
  end

  assign data_io = drv_q ? dout_q : 'z;
endmodule

// File: rtl/epc_checker.sv
module epc_checker
  import epc_pkg::*;
#(
  parameter int unsigned LOAD_WIN = 16,
  parameter int unsigned PAGE_W   = 4,
  parameter int unsigned LW_W     = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input epc_state_e        state_i,
  input logic [PAGE_W-1:0] page_i,
  input logic              toggle_i,
  input logic [LW_W-1:0]   lcnt_i,
  input logic              armed_i,
  input logic              wr_commit_i
);
  AST_PROG_AFTER_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_PROG && $past(state_i) != ST_PROG) |-> $past(state_i) == ST_LOAD); // R6

  AST_LOAD_WIN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcnt_i < LW_W'(LOAD_WIN)); // R6

  AST_PAGE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_LOAD && $past(state_i) == ST_LOAD) |-> $stable(page_i)); // R5

  AST_ARMED_IDLE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_i |-> state_i == ST_IDLE); // R4

  AST_TOGGLE_QUIET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE && $past(state_i) == ST_IDLE) |-> $stable(toggle_i)); // R9

  AST_LOAD_FROM_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_LOAD && $past(state_i) == ST_IDLE) |-> $past(wr_commit_i)); // R3
endmodule

bind eeprom_page_ctrl epc_checker #(
  .LOAD_WIN(LOAD_WIN), .PAGE_W(PAGE_W), .LW_W(LW_W)
) i_epc_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .state_i(state_q), .page_i(page_q),
  .toggle_i(toggle_q), .lcnt_i(lcnt_q), .armed_i(armed), .wr_commit_i(wr_commit)
);

// File: tb/test_eeprom_page_ctrl.sv
`timescale 1ns/1ps
module test_eeprom_page_ctrl;
  localparam int AW = 11;
  localparam int LW = 40;
  localparam int PC = 120;
  localparam int DEPTH = 2 ** AW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic tb_en = 1'b0;
  logic [7:0] tb_d = '0;
  wire  [7:0] data_w;
  logic [7:0] exp_mem [DEPTH];
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  assign data_w = tb_en ? tb_d : 'z;
  always #4 clk = ~clk;

  eeprom_page_ctrl #(.ADDR_W(AW), .LOAD_WIN(LW), .PROG_CYC(PC)) i_eeprom_page_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_io(data_w),
    .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n)
  );

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] stat(input logic [7:0] d, input logic tg);
    return {~d[7], tg, d[5:0]};
  endfunction

  function automatic logic [AW-1:0] pa(input int page, input int b);
    return AW'(page * 128 + b);
  endfunction

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    addr = a; tb_d = d; tb_en = 1'b1;
    cyc(1); ce_n = 1'b0;
    cyc(1); we_n = 1'b0;
    cyc(4); we_n = 1'b1;
    cyc(1); ce_n = 1'b1; tb_en = 1'b0;
    cyc(2);
  endtask

  // address moves after chip enable falls; data moves before write enable rises
  task automatic wr_skew(input logic [AW-1:0] a0, input logic [AW-1:0] a1,
                         input logic [7:0] d0, input logic [7:0] d1);
    addr = a0; tb_d = d0; tb_en = 1'b1;
    cyc(1); ce_n = 1'b0;
    cyc(4); addr = a1;
    cyc(4); we_n = 1'b0;
    cyc(4); tb_d = d1;
    cyc(4); we_n = 1'b1;
    cyc(1); ce_n = 1'b1; tb_en = 1'b0;
    cyc(2);
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] v);
    addr = a;
    cyc(1); ce_n = 1'b0; oe_n = 1'b0;
    cyc(6); @(negedge clk); v = data_w;
    oe_n = 1'b1; ce_n = 1'b1;
    cyc(5);
  endtask

  task automatic unlock();
    wr(AW'(16'h5555), 8'hAA);
    wr(AW'(16'h2AAA), 8'h55);
    wr(AW'(16'h5555), 8'hA0);
  endtask

  task automatic wait_done();
    cyc(LW + PC + 30);
  endtask

  task automatic sweep(input string tag);
    logic [7:0] v;
    for (int a = 0; a < DEPTH; a++) begin
      rd(AW'(a), v);
      chk(tag, v, exp_mem[a]);
    end
  endtask

  initial begin
    cyc(190000);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v, d, last;
    for (int a = 0; a < DEPTH; a++) exp_mem[a] = 8'hFF;
    cyc(3); rst_n = 1'b1; cyc(3);

    // R1 R2: erased array after reset
    sweep("R1_R2 reset contents");

    // R4 R5 R6 R9: full page with unlock, polling in both toggle phases
    unlock();
    last = '0;
    for (int b = 0; b < 128; b++) begin
      d = 8'(b * 37) ^ 8'h5C;
      wr(pa(1, b), d);
      exp_mem[pa(1, b)] = d;
      last = d;
    end
    rd(pa(2, 7), v); chk("R9 first busy read", v, stat(last, 1'b1));
    rd(pa(1, 0), v); chk("R9 second busy read", v, stat(last, 1'b0));
    cyc(LW + PC - 25 - 24);
    rd(pa(1, 0), v); chk("R6 still busy near deadline", v, stat(last, 1'b1));
    cyc(40);
    rd(pa(1, 0), v); chk("R6 idle after programming", v, exp_mem[pa(1, 0)]);
    rd(pa(1, 127), v); chk("R7 last loaded byte", v, exp_mem[pa(1, 127)]);
    rd(AW'(16'h5555), v); chk("R4 command address not stored", v, 8'hFF);
    rd(AW'(16'h2AAA), v); chk("R4 command address not stored", v, 8'hFF);

    // R7 R5: out-of-order, rewrite, stray page
    unlock();
    wr(pa(3, 5), 8'h11);
    wr(pa(3, 2), 8'h22);
    wr(pa(4, 0), 8'h33);
    wr(pa(3, 5), 8'h44);
    rd(pa(3, 5), v); chk("R5 stray write leaves status data", v, stat(8'h44, 1'b1));
    wait_done();
    exp_mem[pa(3, 5)] = 8'h44;
    exp_mem[pa(3, 2)] = 8'h22;
    rd(pa(3, 5), v); chk("R7 rewrite last value wins", v, 8'h44);
    rd(pa(4, 0), v); chk("R5 other page dropped", v, 8'hFF);

    // R7: single byte over an already programmed page
    unlock();
    wr(pa(1, 9), 8'h0F);
    exp_mem[pa(1, 9)] = 8'h0F;
    wait_done();
    rd(pa(1, 10), v); chk("R7 neighbour unchanged", v, exp_mem[pa(1, 10)]);

    // R8: write with no unlock
    wr(pa(6, 1), 8'h5A);
    rd(pa(6, 1), v); chk("R8 unlocked-less write busy", v, stat(8'h5A, 1'b1));
    wait_done();
    rd(pa(6, 1), v); chk("R8 nothing stored", v, 8'hFF);

    // R8: broken unlock sequence
    wr(AW'(16'h5555), 8'hAA);
    wr(AW'(16'h2AAA), 8'h54);
    rd(pa(7, 0), v); chk("R8 mismatch starts busy", v, stat(8'h54, 1'b1));
    wait_done();
    wr(AW'(16'h5555), 8'hA0);
    wr(pa(7, 0), 8'h77);
    wait_done();
    rd(pa(7, 0), v); chk("R8 broken sequence stores nothing", v, 8'hFF);

    // R3: inhibited writes after unlock keep the block idle and armed
    unlock();
    addr = pa(8, 0); tb_d = 8'h99; tb_en = 1'b1;
    cyc(1); ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b0;
    cyc(6); we_n = 1'b1; oe_n = 1'b1; ce_n = 1'b1;
    cyc(1); tb_en = 1'b0; cyc(3);
    rd(pa(8, 0), v); chk("R3 output enable low inhibits write", v, 8'hFF);
    addr = pa(8, 0); tb_d = 8'h98; tb_en = 1'b1;
    cyc(1); we_n = 1'b0;
    cyc(6); we_n = 1'b1;
    cyc(1); tb_en = 1'b0; cyc(3);
    rd(pa(8, 0), v); chk("R3 chip enable high inhibits write", v, 8'hFF);
    wr(pa(8, 1), 8'h66);
    exp_mem[pa(8, 1)] = 8'h66;
    wait_done();
    rd(pa(8, 1), v); chk("R3 armed write after inhibited ones", v, 8'h66);

    // R3: address at later falling edge, data at first rising edge
    unlock();
    wr_skew(pa(9, 3), pa(9, 4), 8'hEE, 8'h3C);
    exp_mem[pa(9, 4)] = 8'h3C;
    wait_done();
    rd(pa(9, 4), v); chk("R3 late address and data taken", v, 8'h3C);
    rd(pa(9, 3), v); chk("R3 early address unused", v, 8'hFF);

    // R10: write during programming ignored
    unlock();
    wr(pa(11, 0), 8'hA5);
    exp_mem[pa(11, 0)] = 8'hA5;
    cyc(LW + 20);
    wr(pa(11, 1), 8'h12);
    rd(pa(11, 1), v); chk("R10 status ignores write in programming", v, stat(8'hA5, 1'b1));
    wait_done();
    rd(pa(11, 1), v); chk("R10 ignored byte not stored", v, 8'hFF);

    // R7 R5 R8 R4: whole array against the model
    sweep("R7 final contents");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule